// File: doc/BRIEF.md
# Lockable MMIO Range Router

This block decides where a memory-mapped I/O request goes. It holds eight programmable windows. Each window is described by a pair of 32-bit words: a start word and an end word. Together they cover a 40-bit address space in 64 KB steps. A request carries an address, a read/write flag and a flag that marks it as coming from a CPU. For each request the block returns the target node, the target link, whether writes into that window must be non-posted, and which window matched.

Software programs the windows through a simple write-only register port that selects a window index and one of its two words. Each start word carries several controls:

- a read enable and a write enable;
- a CPU-exclusion control that makes the window invisible to CPU-originated traffic;
- a freeze control that makes both words of the window read-only until the next reset.

When more than one window matches, the lowest-numbered one wins. The answer is registered and appears one clock after the request is presented.

Top module: `mmio_range_router`

## Requirements
- R1: After reset every window is cleared, so no request hits. All response outputs read zero until windows are programmed. A later reset clears all windows again, including frozen ones.
- R2: A window matches when request address bits 39:16 lie between the start field and the end field, both limits inclusive. Both fields sit at word bits 31:8. One step below the start or above the end does not match.
- R3: In the start word, bit 0 enables reads and bit 1 enables writes. A read into a window without bit 0 does not match, and a write into a window without bit 1 does not match.
- R4: When start-word bit 2 is set, a request with the CPU flag high does not match that window. The same request with the CPU flag low still matches.
- R5: When start-word bit 3 is set, later writes to both words of that window are ignored. A write cannot clear bit 3; only reset clears it.
- R6: On a hit, the response reports fields taken from the end word of the winning window:
  - the node from bits 2:0;
  - the link from bits 5:4;
  - the non-posted flag from bit 7.
- R7: A window whose end word holds link value 3 never matches. Reprogramming it with a valid link makes it match.
- R8: When several windows match, the response names the lowest-numbered one.
- R9: When no window matches, or when req_valid is low, rsp_hit is low and node, link, non-posted and index all read zero.
- R10: The response to a request presented in one cycle appears after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel_limit | input | 1 | 0 selects the start word, 1 selects the end word |
| cfg_idx | input | 3 | Window index for the write |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Request present |
| req_addr | input | 40 | Request byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_cpu | input | 1 | Request originates from a CPU |
| rsp_hit | output | 1 | A window matched |
| rsp_node | output | 3 | Destination node of the winning window |
| rsp_link | output | 2 | Destination link of the winning window |
| rsp_nonposted | output | 1 | Writes to the winning window must be non-posted |
| rsp_idx | output | 3 | Index of the winning window |

## Verification
The match logic is tried with addresses placed exactly on a start field, exactly on an end field, and one 64 KB step outside each. This separates an inclusive compare from an exclusive or off-by-one compare. The same address is then sent as a read and as a write, and with and without the CPU flag. These pairs separate the read-enable, write-enable and CPU-exclusion gates from the range compare. Two overlapping windows show that the lower index wins. A window set to the reserved link value is tested first as programmed and then after it is rewritten with a valid link. Rewrites of a frozen window, followed by requests into it, show whether the freeze held. A final reset shows that the freeze was lifted.

// File: rtl/mmio_rr_pkg.sv
// Shared field layouts for the MMIO range router.
// Assumes 40-bit byte addresses and 64 KB window granularity.
package mmio_rr_pkg;
    localparam int ADDR_W    = 40;
    localparam int GRAN_W    = 16;
    localparam int RNG_W     = ADDR_W - GRAN_W;
    localparam int WORD_W    = 32;
    localparam logic [1:0] LINK_RSVD = 2'd3;

    // Start word: window start plus access controls.
    typedef struct packed {
        logic [RNG_W-1:0] addr;    // bits 31:8
        logic [3:0]       rsvd;    // bits 7:4
        logic             lock;    // bit 3
        logic             cpu_off; // bit 2
        logic             wr_en;   // bit 1
        logic             rd_en;   // bit 0
    } start_word_t;

    // End word: window end plus routing attributes.
    typedef struct packed {
        logic [RNG_W-1:0] addr;    // bits 31:8
        logic             np;      // bit 7
        logic             rsvd1;   // bit 6
        logic [1:0]       link;    // bits 5:4
        logic             rsvd0;   // bit 3
        logic [2:0]       node;    // bits 2:0
    } end_word_t;
endpackage

// File: rtl/mmio_rr_regfile.sv
// Holds the start and end words of every window.
// Assumes one write per cycle. A window whose freeze bit is set ignores writes to both of its words.
module mmio_rr_regfile
    import mmio_rr_pkg::*;
#(
    parameter int N_PAIRS = 8,
    parameter int IDX_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic                            cfg_sel_limit,
    input  logic [IDX_W-1:0]                cfg_idx,
    input  logic [WORD_W-1:0]               cfg_wdata,
    output start_word_t [N_PAIRS-1:0]       start_q,
    output end_word_t   [N_PAIRS-1:0]       end_q
);
    // Update the addressed word unless its window is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N_PAIRS; i++) begin
                if (cfg_idx == IDX_W'(i) && !start_q[i].lock) begin
                    if (cfg_sel_limit)
                        end_q[i] <= end_word_t'(cfg_wdata);
                    else
                        start_q[i] <= start_word_t'(cfg_wdata);
                end
            end
        end
    end
endmodule

// File: rtl/mmio_rr_match.sv
// Decides whether one window accepts a request.
// Assumes the caller supplies address bits 39:16 only; purely combinational.
module mmio_rr_match
    import mmio_rr_pkg::*;
(
    input  start_word_t      sw,
    input  end_word_t        ew,
    input  logic [RNG_W-1:0] addr_hi,
    input  logic             is_wr,
    input  logic             is_cpu,
    output logic             hit
);
    logic in_rng, type_ok, cpu_ok, link_ok;
    logic unused_fields;

    // Inclusive range compare and the access, CPU and link qualifiers.
    always_comb begin
        in_rng  = (addr_hi >= sw.addr) && (addr_hi <= ew.addr);
        type_ok = is_wr ? sw.wr_en : sw.rd_en;
        cpu_ok  = !(is_cpu && sw.cpu_off);
        link_ok = (ew.link != LINK_RSVD);
        hit     = in_rng && type_ok && cpu_ok && link_ok;
    end

    // Fields that the match ignores.
    assign unused_fields = ^{sw.rsvd, sw.lock, ew.np, ew.rsvd1, ew.rsvd0, ew.node};
endmodule

// File: rtl/mmio_rr_pick.sv
// Selects the lowest-numbered asserted bit of a hit vector.
// Assumes the index output is don't-care when 'any' is low; it is then driven to zero.
module mmio_rr_pick #(
    parameter int N_PAIRS = 8,
    parameter int IDX_W   = 3
) (
    input  logic [N_PAIRS-1:0] hit_vec,
    output logic               any,
    output logic [IDX_W-1:0]   win
);
    // Scan from the top down so the lowest hitting index is assigned last.
    always_comb begin
        any = |hit_vec;
        win = '0;
        for (int i = N_PAIRS - 1; i >= 0; i--) begin
            if (hit_vec[i])
                win = IDX_W'(i);
        end
    end
endmodule

// File: rtl/mmio_range_router.sv
// Routes MMIO requests to a node and link through programmable, freezable windows.
// Assumes synchronous active-low reset. The response is registered one cycle after the request.
module mmio_range_router
    import mmio_rr_pkg::*;
#(
    parameter  int N_PAIRS = 8,
    localparam int IDX_W   = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel_limit,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_cpu,
    output logic              rsp_hit,
    output logic [2:0]        rsp_node,
    output logic [1:0]        rsp_link,
    output logic              rsp_nonposted,
    output logic [IDX_W-1:0]  rsp_idx
);
    start_word_t [N_PAIRS-1:0] start_q;
    end_word_t   [N_PAIRS-1:0] end_q;
    logic        [N_PAIRS-1:0] hit_vec;
    logic        [N_PAIRS-1:0] lock_vec;
    logic                      any_hit;
    logic        [IDX_W-1:0]   win;
    logic        [RNG_W-1:0]   addr_hi;
    logic                      unused_low;

    assign addr_hi    = req_addr[ADDR_W-1:GRAN_W];
    assign unused_low = ^req_addr[GRAN_W-1:0];

    mmio_rr_regfile #(.N_PAIRS(N_PAIRS), .IDX_W(IDX_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_sel_limit (cfg_sel_limit),
        .cfg_idx       (cfg_idx),
        .cfg_wdata     (cfg_wdata),
        .start_q       (start_q),
        .end_q         (end_q)
    );

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_win
        mmio_rr_match u_match (
            .sw      (start_q[g]),
            .ew      (end_q[g]),
            .addr_hi (addr_hi),
            .is_wr   (req_write),
            .is_cpu  (req_cpu),
            .hit     (hit_vec[g])
        );
    end

    mmio_rr_pick #(.N_PAIRS(N_PAIRS), .IDX_W(IDX_W)) u_pick (
        .hit_vec (hit_vec),
        .any     (any_hit),
        .win     (win)
    );

    // Gather the freeze bits for observation.
    always_comb begin
        for (int i = 0; i < N_PAIRS; i++)
            lock_vec[i] = start_q[i].lock;
    end

    // Register the winning window's attributes, or all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid || !any_hit) begin
            rsp_hit       <= 1'b0;
            rsp_idx       <= '0;
            rsp_node      <= '0;
            rsp_link      <= '0;
            rsp_nonposted <= 1'b0;
        end else begin
            rsp_hit       <= 1'b1;
            rsp_idx       <= win;
            rsp_node      <= end_q[win].node;
            rsp_link      <= end_q[win].link;
            rsp_nonposted <= end_q[win].np;
        end
    end
endmodule

// Checker for the MMIO range router, attached by bind.
// Assumes the checker sees the packed window words and freeze bits of the instance.
module mmio_rr_checker #(
    parameter int N_PAIRS = 8,
    parameter int IDX_W   = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   rsp_hit,
    input logic [2:0]             rsp_node,
    input logic [1:0]             rsp_link,
    input logic                   rsp_nonposted,
    input logic [IDX_W-1:0]       rsp_idx,
    input logic [N_PAIRS-1:0]     lock_vec,
    input logic [N_PAIRS*32-1:0]  start_vec,
    input logic [N_PAIRS*32-1:0]  end_vec
);
    logic                  armed;
    logic                  vld_q;
    logic [N_PAIRS-1:0]    lock_q;
    logic [N_PAIRS*32-1:0] start_prev, end_prev, frz_mask;

    // Track one cycle of history after reset.
    always_ff @(posedge clk) begin
        armed      <= rst_n;
        vld_q      <= rst_n && req_valid;
        lock_q     <= rst_n ? lock_vec : '0;
        start_prev <= start_vec;
        end_prev   <= end_vec;
    end

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_mask
        assign frz_mask[g*32 +: 32] = {32{lock_q[g]}};
    end

    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((lock_vec & lock_q) == lock_q));
    p_frozen_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (((start_vec ^ start_prev) & frz_mask) == '0));
    p_frozen_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (((end_vec ^ end_prev) & frz_mask) == '0));
    p_no_rsvd_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_link != 2'd3));
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_node == '0 && rsp_link == '0 && !rsp_nonposted && rsp_idx == '0));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !vld_q) |-> !rsp_hit);
endmodule

bind mmio_range_router mmio_rr_checker #(.N_PAIRS(N_PAIRS), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rsp_hit       (rsp_hit),
    .rsp_node      (rsp_node),
    .rsp_link      (rsp_link),
    .rsp_nonposted (rsp_nonposted),
    .rsp_idx       (rsp_idx),
    .lock_vec      (lock_vec),
    .start_vec     (start_q),
    .end_vec       (end_q)
);

// File: tb/sim_mmio_range_router.sv
`timescale 1ns/1ps
module sim_mmio_range_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel_limit = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_cpu = 1'b0;
    logic [39:0] req_addr = '0;
    logic        rsp_hit, rsp_nonposted;
    logic [2:0]  rsp_node, rsp_idx;
    logic [1:0]  rsp_link;
    int          n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    mmio_range_router u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel_limit(cfg_sel_limit), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_cpu(req_cpu),
        .rsp_hit(rsp_hit), .rsp_node(rsp_node), .rsp_link(rsp_link),
        .rsp_nonposted(rsp_nonposted), .rsp_idx(rsp_idx)
    );

    // Vector layout: [39:16] addr hi, [15] wr, [14] cpu, [13] hit, [12:10] idx,
    // [9:7] node, [6:5] link, [4] np, [3:0] zero.
    localparam int NV = 14;
    localparam logic [39:0] VEC [NV] = '{
        {24'h000100, 1'b0, 1'b0, 1'b1, 3'd0, 3'd1, 2'd0, 1'b0, 4'd0}, // R2 start edge
        {24'h0000FF, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 4'd0}, // R2 below start
        {24'h0001FF, 1'b1, 1'b0, 1'b1, 3'd0, 3'd1, 2'd0, 1'b0, 4'd0}, // R2 end edge
        {24'h000200, 1'b0, 1'b0, 1'b1, 3'd1, 3'd2, 2'd1, 1'b1, 4'd0}, // R6 fields of window 1
        {24'h000200, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 4'd0}, // R3 write without enable
        {24'h000180, 1'b0, 1'b1, 1'b1, 3'd0, 3'd1, 2'd0, 1'b0, 4'd0}, // R8 overlap, lower wins
        {24'h000300, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 4'd0}, // R9 gap
        {24'h001000, 1'b1, 1'b0, 1'b1, 3'd2, 3'd3, 2'd2, 1'b0, 4'd0}, // R4 non-CPU hits
        {24'h001000, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 4'd0}, // R4 CPU excluded
        {24'h001000, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 4'd0}, // R3 read without enable
        {24'h002800, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 4'd0}, // R7 reserved link
        {24'h003000, 1'b1, 1'b1, 1'b1, 3'd4, 3'd5, 2'd1, 1'b1, 4'd0}, // R6 frozen window fields
        {24'h0030FF, 1'b0, 1'b0, 1'b1, 3'd4, 3'd5, 2'd1, 1'b1, 4'd0}, // R2 end edge
        {24'h003100, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 4'd0}  // R2 above end
    };
    localparam string VTAG [NV] = '{"R2", "R2", "R2", "R6", "R3", "R8", "R9",
                                    "R4", "R4", "R3", "R7", "R6", "R2", "R2"};

    function automatic logic [31:0] sw_word(logic [23:0] a, logic lk, logic co, logic we, logic re);
        return {a, 4'b0, lk, co, we, re};
    endfunction

    function automatic logic [31:0] ew_word(logic [23:0] a, logic np, logic [1:0] lnk, logic [2:0] nd);
        return {a, np, 1'b0, lnk, 1'b0, nd};
    endfunction

    function automatic logic [9:0] rsp_now();
        return {rsp_hit, rsp_idx, rsp_node, rsp_link, rsp_nonposted};
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [2:0] idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel_limit = sel; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req(logic [23:0] hi, logic w, logic c, output logic [9:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_addr = {hi, 16'hA5C3}; req_write = w; req_cpu = c;
        @(negedge clk);
        r = rsp_now();
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
    end

    initial begin
        logic [9:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs", rsp_now(), 10'd0);
        req(24'h000000, 1'b0, 1'b0, r);
        check("R1 nothing programmed", r, 10'd0);

        // Program windows: end words first, then start words.
        wr(1, 0, ew_word(24'h0001FF, 0, 2'd0, 3'd1));
        wr(0, 0, sw_word(24'h000100, 0, 0, 1, 1));
        wr(1, 1, ew_word(24'h0002FF, 1, 2'd1, 3'd2));
        wr(0, 1, sw_word(24'h000180, 0, 0, 0, 1));
        wr(1, 2, ew_word(24'h001000, 0, 2'd2, 3'd3));
        wr(0, 2, sw_word(24'h001000, 0, 1, 1, 0));
        wr(1, 3, ew_word(24'h002FFF, 0, 2'd3, 3'd4));
        wr(0, 3, sw_word(24'h002000, 0, 0, 1, 1));
        wr(1, 4, ew_word(24'h0030FF, 1, 2'd1, 3'd5));
        wr(0, 4, sw_word(24'h003000, 1, 0, 1, 1));

        for (int i = 0; i < NV; i++) begin
            req(VEC[i][39:16], VEC[i][15], VEC[i][14], r);
            check(VTAG[i], r, VEC[i][13:4]);
        end

        // R5: writes to a frozen window are ignored.
        wr(0, 4, 32'h0);
        req(24'h003000, 1'b0, 1'b0, r);
        check("R5 frozen start kept", r, {1'b1, 3'd4, 3'd5, 2'd1, 1'b1});
        wr(1, 4, ew_word(24'h0030FF, 0, 2'd0, 3'd7));
        req(24'h003000, 1'b0, 1'b0, r);
        check("R5 frozen end kept", r, {1'b1, 3'd4, 3'd5, 2'd1, 1'b1});

        // R7: a valid link makes window 3 match.
        wr(1, 3, ew_word(24'h002FFF, 0, 2'd0, 3'd6));
        req(24'h002800, 1'b0, 1'b0, r);
        check("R7 valid link hits", r, {1'b1, 3'd3, 3'd6, 2'd0, 1'b0});

        // R9: idle request slot gives zero outputs.
        @(negedge clk);
        req_valid = 1'b0; req_addr = {24'h000100, 16'h0}; req_write = 1'b0;
        @(negedge clk);
        check("R9 valid low", rsp_now(), 10'd0);

        // R10: no response before the edge, response after it.
        @(negedge clk);
        req_valid = 1'b1; req_addr = {24'h000100, 16'h0};
        #1 check("R10 before edge", rsp_now(), 10'd0);
        @(negedge clk);
        check("R10 after edge", rsp_now(), {1'b1, 3'd0, 3'd1, 2'd0, 1'b0});
        req_valid = 1'b0;

        // R1 and R5: reset clears windows, including the freeze bit.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        req(24'h003000, 1'b0, 1'b0, r);
        check("R1 reset clears frozen window", r, 10'd0);
        wr(1, 4, ew_word(24'h0030FF, 0, 2'd2, 3'd2));
        wr(0, 4, sw_word(24'h003000, 0, 0, 0, 1));
        req(24'h003000, 1'b0, 1'b0, r);
        check("R5 writable after reset", r, {1'b1, 3'd4, 3'd2, 2'd2, 1'b0});
        wr(0, 4, sw_word(24'h003000, 0, 0, 0, 0));
        req(24'h003000, 1'b0, 1'b0, r);
        check("R5 unfrozen rewrite takes effect", r, 10'd0);

        summary();
    end
endmodule